// File: doc/BRIEF.md
# FIFO Occupancy Level Flag Generator

This block watches the stored word count of a 512-deep FIFO and turns it into two registered status flags. The first, `half_full`, says whether at least half of the storage is in use. The second, `edge_flag`, marks that the level is near either end of the FIFO. Near the empty end, the count is at or below a low-side offset. Near the full end, the count is at or above the depth minus a high-side offset.

The two offsets are held in registers. Each one loads from its own input on a clock edge where the load strobe is high. Reset returns both offsets to 128. While reset is held, `edge_flag` is forced high and `half_full` is held low.

The count is taken as already synchronous to `clk`. Moving occupancy across clock domains is left to the surrounding logic.

Top module: `fifo_level_flags`

## Requirements
- R1: While `rst_n` is low, `edge_flag` is 1 and `half_full` is 0. Reset returns the low offset and the high offset to 128, so after reset, count 128 gives `edge_flag`=1 and count 129 gives 0.
- R2: `edge_flag` is 1 when the count is less than or equal to the low offset.
- R3: `edge_flag` is 1 when the count is greater than or equal to 512 minus the high offset. This includes a high offset of 0, where only count 512 sets the flag.
- R4: `edge_flag` is 0 when the count is strictly greater than the low offset and strictly less than 512 minus the high offset.
- R5: `half_full` is 1 exactly when the count is 256 or more.
- R6: Both flags are registered. Each rising edge presents the flags for the count and offsets sampled at that edge, and the outputs do not change between edges.
- R7: On a rising edge where `ofs_load` is 1, both offsets load from `lo_ofs_in` and `hi_ofs_in`. The new offsets act on the flags from the following edge onward. While `ofs_load` is 0, changes on the offset inputs have no effect.
- R8: When the programmed offsets make the two ranges overlap, `edge_flag` stays 1 for every count.
- R9: A count above 512 is treated as 512, so both flags are 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lvl_count | input | 10 | Current stored word count, 0 to 512 |
| lo_ofs_in | input | 9 | New near-empty offset |
| hi_ofs_in | input | 9 | New near-full offset |
| ofs_load | input | 1 | Loads both offsets on the rising edge |
| half_full | output | 1 | Count is at least half the depth |
| edge_flag | output | 1 | Count is near empty or near full |

## Verification
A new count is visible on both flags right after the next rising edge. The bench drives each count on a falling edge and samples shortly after the following rising edge. For R6, it also samples just before that edge to confirm the old flag values still hold.

An offset load takes two edges to show on the flags: one edge to store the offset and one to register the flags. The bench therefore spends a full cycle on the load before it applies the count that tests the new offsets.

Reset acts at once, so the reset checks sample while `rst_n` is still low.

// File: rtl/lvl_pkg.sv
package lvl_pkg;

  // Clamp an occupancy value to the storage depth.
  function automatic int unsigned clamp_count(int unsigned cnt, int unsigned depth);
    return (cnt > depth) ? depth : cnt;
  endfunction

  // Near-empty test: count at or below the low offset.
  function automatic logic is_near_empty(int unsigned cnt, int unsigned lo_ofs);
    return cnt <= lo_ofs;
  endfunction

  // Near-full test: count + offset reaches depth (no subtraction underflow).
  function automatic logic is_near_full(int unsigned cnt, int unsigned hi_ofs,
                                        int unsigned depth);
    return (cnt + hi_ofs) >= depth;
  endfunction

  // Half test: twice the count reaches depth.
  function automatic logic is_half(int unsigned cnt, int unsigned depth);
    return (cnt * 2) >= depth;
  endfunction

endpackage

// File: rtl/lvl_ofs_reg.sv
module lvl_ofs_reg #(
  parameter int W       = 9,
  parameter int RST_VAL = 128
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  localparam logic [W-1:0] RST_Q = W'(RST_VAL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= RST_Q;
    else if (load) q <= d;
  end

endmodule

// File: rtl/lvl_cmp.sv
module lvl_cmp #(
  parameter int DEPTH = 512,
  parameter int CNT_W = 10,
  parameter int OFS_W = 9
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic [OFS_W-1:0] lo_ofs,
  input  logic [OFS_W-1:0] hi_ofs,
  output logic             near_empty,
  output logic             near_full,
  output logic             half
);
  import lvl_pkg::*;

  int unsigned cnt_c;

  always_comb begin
    cnt_c      = clamp_count(32'(cnt), DEPTH);
    near_empty = is_near_empty(cnt_c, 32'(lo_ofs));
    near_full  = is_near_full(cnt_c, 32'(hi_ofs), DEPTH);
    half       = is_half(cnt_c, DEPTH);
  end

endmodule

// File: rtl/lvl_flag_reg.sv
module lvl_flag_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic near_empty,
  input  logic near_full,
  input  logic half,
  output logic edge_flag,
  output logic half_full
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_flag <= 1'b1;
      half_full <= 1'b0;
    end else begin
      edge_flag <= near_empty | near_full;
      half_full <= half;
    end
  end

endmodule

// File: rtl/fifo_level_flags.sv
module fifo_level_flags #(
  parameter int DEPTH   = 512,
  parameter int DEF_OFS = 128,
  parameter int CNT_W   = $clog2(DEPTH) + 1,
  parameter int OFS_W   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] lvl_count,
  input  logic [OFS_W-1:0] lo_ofs_in,
  input  logic [OFS_W-1:0] hi_ofs_in,
  input  logic             ofs_load,
  output logic             half_full,
  output logic             edge_flag
);

  localparam int N_OFS = 2;  // index 0: low side, 1: high side

  logic [OFS_W-1:0] ofs_d [N_OFS];
  logic [OFS_W-1:0] ofs_q [N_OFS];

  // Named internal events for the checker.
  logic [OFS_W-1:0] lo_ofs_q;
  logic [OFS_W-1:0] hi_ofs_q;
  logic             near_empty_w;
  logic             near_full_w;
  logic             half_w;

  assign ofs_d[0] = lo_ofs_in;
  assign ofs_d[1] = hi_ofs_in;

  for (genvar i = 0; i < N_OFS; i++) begin : g_ofs
    lvl_ofs_reg #(.W(OFS_W), .RST_VAL(DEF_OFS)) ofs_i (
      .clk  (clk),
      .rst_n(rst_n),
      .load (ofs_load),
      .d    (ofs_d[i]),
      .q    (ofs_q[i])
    );
  end

  assign lo_ofs_q = ofs_q[0];
  assign hi_ofs_q = ofs_q[1];

  lvl_cmp #(.DEPTH(DEPTH), .CNT_W(CNT_W), .OFS_W(OFS_W)) cmp_i (
    .cnt       (lvl_count),
    .lo_ofs    (lo_ofs_q),
    .hi_ofs    (hi_ofs_q),
    .near_empty(near_empty_w),
    .near_full (near_full_w),
    .half      (half_w)
  );

  lvl_flag_reg flag_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .near_empty(near_empty_w),
    .near_full (near_full_w),
    .half      (half_w),
    .edge_flag (edge_flag),
    .half_full (half_full)
  );

endmodule

// File: rtl/lvl_flags_chk.sv
module lvl_flags_chk #(
  parameter int DEPTH = 512,
  parameter int CNT_W = 10,
  parameter int OFS_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] lvl_count,
  input logic             ofs_load,
  input logic [OFS_W-1:0] lo_ofs_q,
  input logic [OFS_W-1:0] hi_ofs_q,
  input logic             near_empty_w,
  input logic             near_full_w,
  input logic             edge_flag,
  input logic             half_full
);

  localparam int HALF = DEPTH / 2;

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R1: flags held at their reset values during reset
  always @(negedge clk) begin
    if (!rst_n) a_r1_reset_flags: assert (edge_flag && !half_full);
  end

  a_r2_near_empty_sets: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(near_empty_w) |-> edge_flag);

  a_r3_near_full_sets: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(near_full_w) |-> edge_flag);

  a_r4_mid_clears: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && !$past(near_empty_w) && !$past(near_full_w) |-> !edge_flag);

  a_r5_half_level: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> half_full == (32'($past(lvl_count)) >= HALF));

  a_r7_ofs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && !$past(ofs_load) |-> $stable(lo_ofs_q) && $stable(hi_ofs_q));

endmodule

bind fifo_level_flags lvl_flags_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W), .OFS_W(OFS_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .lvl_count   (lvl_count),
  .ofs_load    (ofs_load),
  .lo_ofs_q    (lo_ofs_q),
  .hi_ofs_q    (hi_ofs_q),
  .near_empty_w(near_empty_w),
  .near_full_w (near_full_w),
  .edge_flag   (edge_flag),
  .half_full   (half_full)
);

// File: tb/fifo_level_flags_tb.sv
module fifo_level_flags_tb_top;

  localparam int CLK_P = 10;
  localparam int NVEC  = 12;

  typedef struct packed {
    logic [9:0] cnt;
    logic       ef;
    logic       hf;
  } vec_t;

  // Default offsets (128/128): edge set at <=128 and >=384, half at >=256.
  localparam vec_t VEC [NVEC] = '{
    '{10'd0,   1'b1, 1'b0}, '{10'd1,   1'b1, 1'b0},
    '{10'd128, 1'b1, 1'b0}, '{10'd129, 1'b0, 1'b0},
    '{10'd200, 1'b0, 1'b0}, '{10'd255, 1'b0, 1'b0},
    '{10'd256, 1'b0, 1'b1}, '{10'd383, 1'b0, 1'b1},
    '{10'd384, 1'b1, 1'b1}, '{10'd511, 1'b1, 1'b1},
    '{10'd512, 1'b1, 1'b1}, '{10'd700, 1'b1, 1'b1}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] lvl_count = '0;
  logic [8:0] lo_ofs_in = '0;
  logic [8:0] hi_ofs_in = '0;
  logic       ofs_load = 1'b0;
  logic       half_full, edge_flag;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  fifo_level_flags dut_i (
    .clk(clk), .rst_n(rst_n), .lvl_count(lvl_count),
    .lo_ofs_in(lo_ofs_in), .hi_ofs_in(hi_ofs_in), .ofs_load(ofs_load),
    .half_full(half_full), .edge_flag(edge_flag)
  );

  // Bench model: flag clear only strictly inside the window.
  function automatic logic mdl_edge(int c, int x, int y);
    int cc = (c > 512) ? 512 : c;
    return !((cc > x) && (cc < 512 - y));
  endfunction

  function automatic logic mdl_half(int c);
    return c >= 256;
  endfunction

  task automatic check(string tag, logic act, logic exp_v, string what);
    n_chk++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b (count %0d)",
               tag, what, act, exp_v, lvl_count);
    end
  endtask

  task automatic apply(logic [9:0] c, logic ef, logic hf, string tag);
    @(negedge clk);
    lvl_count = c;
    @(posedge clk);
    #1;
    check(tag, edge_flag, ef, "edge_flag");
    check(tag, half_full, hf, "half_full");
  endtask

  task automatic load_ofs(logic [8:0] x, logic [8:0] y);
    @(negedge clk);
    lo_ofs_in = x;
    hi_ofs_in = y;
    ofs_load  = 1'b1;
    @(negedge clk);
    ofs_load  = 1'b0;
  endtask

  initial begin
    #(CLK_P * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    lvl_count = 10'd300;
    #(CLK_P * 2 + 2);
    check("R1", edge_flag, 1'b1, "edge_flag in reset");
    check("R1", half_full, 1'b0, "half_full in reset");
    @(negedge clk);
    rst_n = 1'b1;

    // Default offsets, table walk (R2 R3 R4 R5 R9)
    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i].cnt, VEC[i].ef, VEC[i].hf, "R2_R3_R4_R5_R9 table");
    end

    // R6: output holds until the edge
    apply(10'd200, 1'b0, 1'b0, "R6");
    @(negedge clk);
    lvl_count = 10'd450;
    #(CLK_P/2 - 1);
    check("R6", edge_flag, 1'b0, "edge_flag before edge");
    check("R6", half_full, 1'b0, "half_full before edge");
    @(posedge clk);
    #1;
    check("R6", edge_flag, 1'b1, "edge_flag after edge");
    check("R6", half_full, 1'b1, "half_full after edge");

    // R7: programmed offsets 10 / 20 -> thresholds 10 and 492
    load_ofs(9'd10, 9'd20);
    apply(10'd10,  mdl_edge(10, 10, 20),  mdl_half(10),  "R7 R2");
    apply(10'd11,  mdl_edge(11, 10, 20),  mdl_half(11),  "R7 R4");
    apply(10'd491, mdl_edge(491, 10, 20), mdl_half(491), "R7 R4");
    apply(10'd492, mdl_edge(492, 10, 20), mdl_half(492), "R7 R3");

    // R7: inputs change without load -> offsets unchanged
    @(negedge clk);
    lo_ofs_in = 9'd400;
    hi_ofs_in = 9'd400;
    @(negedge clk);
    apply(10'd300, mdl_edge(300, 10, 20), mdl_half(300), "R7 ignore");

    // R3: high offset 0 -> only full count sets flag
    load_ofs(9'd10, 9'd0);
    apply(10'd511, mdl_edge(511, 10, 0), mdl_half(511), "R3 zero ofs");
    apply(10'd512, mdl_edge(512, 10, 0), mdl_half(512), "R3 zero ofs");

    // R8: overlapping ranges (300 / 300 -> 212)
    load_ofs(9'd300, 9'd300);
    apply(10'd256, mdl_edge(256, 300, 300), mdl_half(256), "R8");
    apply(10'd250, mdl_edge(250, 300, 300), mdl_half(250), "R8");

    // R1: reset mid-run, then offsets back to 128
    @(negedge clk);
    lvl_count = 10'd300;
    rst_n = 1'b0;
    #2;
    check("R1", edge_flag, 1'b1, "edge_flag mid reset");
    check("R1", half_full, 1'b0, "half_full mid reset");
    @(negedge clk);
    rst_n = 1'b1;
    apply(10'd129, 1'b0, 1'b0, "R1 default ofs");
    apply(10'd128, 1'b1, 1'b0, "R1 default ofs");
    apply(10'd383, 1'b0, 1'b1, "R1 default ofs");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule